// File: doc/BRIEF.md
# Run-Length Expanding Receive Pipeline

This block sits between the read port of a receive FIFO and the host. Each FIFO entry carries a data character and a command flag. The block moves entries through two holding stages. The second stage is the register the host reads.

When expansion is enabled, a command entry is taken as a run-length code. It is loaded into a count register and is never shown to the host. The next ordinary character is then held in the first stage and replayed into the output stage once per count step, so the host sees it count-plus-one times. After the count is used up, normal flow resumes.

When expansion is disabled, a command entry travels down the pipeline marked with a tag. While it waits in the output stage it holds an interrupt high. A normal pop cannot remove it. Only a dedicated tag read takes it out of the pipeline and clears the tag. While a tagged entry is anywhere in the pipeline, and while a replay is in progress, the FIFO is not read.

Top module: `rle_rx_expander`

## Requirements
- R1: After reset, outValid, outTag and irq are low, and fifoRd stays low while fifoValid is low.
- R2: An entry with fifoCmd=0 is delivered on outData once, with outTag=0, in the order the FIFO supplied it.
- R3: With expandEn=1, an entry with fifoCmd=1 and value N never appears at the output. The next entry with fifoCmd=0 is delivered N+1 times in a row, so N=0 yields one copy.
- R4: A code equal to the largest value of DATA_W bits (2^DATA_W-1) yields 2^DATA_W copies of the following character.
- R5: The FIFO is not read while a replay is in progress. Whenever fifoRd is high, at most one earlier delivered-but-not-removed entry remains in the pipeline after the host removal of that cycle.
- R6: With expandEn=0, an entry with fifoCmd=1 is delivered with outTag=1 and its value on outData. irq is high in every cycle that entry waits at the output.
- R7: hostPop has no effect on a tagged output entry. hostTagRead removes it, and irq is low in the following cycle.
- R8: fifoRd is low while a tagged entry is present in either holding stage.
- R9: hostTagRead while the output entry is untagged has no effect on the output.
- R10: With expandEn=1, when two codes arrive before a character, the later code alone sets the repeat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| expandEn | input | 1 | 1: command entries are run-length codes; 0: command entries are tagged |
| fifoValid | input | 1 | FIFO has an entry at its read port |
| fifoData | input | DATA_W | Character or code value of the FIFO head |
| fifoCmd | input | 1 | 1: the FIFO head is a command (run-length) entry |
| fifoRd | output | 1 | Pops the FIFO head at this clock edge |
| hostPop | input | 1 | Host takes an untagged output entry |
| hostTagRead | input | 1 | Host direct read that removes a tagged output entry |
| outValid | output | 1 | Output holding stage contains an entry |
| outData | output | DATA_W | Output holding stage value |
| outTag | output | 1 | Output entry is a tagged command |
| irq | output | 1 | Tagged entry waiting for a direct read |

## Verification
The bench builds the block with DATA_W=4. With that width, random codes reach the full count range of 0 to 15 within a few hundred entries. The full-scale case of 16 copies is also short enough to drive as a directed run next to random traffic. Random host pops leave the two stages full for varying stretches. This exercises the read gating during replay and while a tag waits, at occupancies that a fully drained pipeline would never show.

// File: rtl/rle_rx_pkg.sv
package rle_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_REPLAY = 2'd2
  } rle_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic loadH1;
    logic h1TagIn;
    logic moveH1;
    logic keepH1;
    logic popH2;
  } rle_strobe_t;

  // flags from datapath to control
  typedef struct packed {
    logic h1Valid;
    logic h1Tag;
    logic h2Valid;
    logic h2Tag;
    logic cntZero;
    logic cntOne;
  } rle_status_t;

endpackage

// File: rtl/rle_rx_datapath.sv
module rle_rx_datapath
  import rle_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rle_strobe_t       stb,
  input  logic [DATA_W-1:0] fifoData,
  output rle_status_t       sts,
  output logic [DATA_W-1:0] outData
);

  localparam logic [DATA_W-1:0] CNT_ONE = DATA_W'(1);

  logic [DATA_W-1:0] cntReg;
  logic [DATA_W-1:0] h1Data;
  logic              h1Valid;
  logic              h1Tag;
  logic [DATA_W-1:0] h2Data;
  logic              h2Valid;
  logic              h2Tag;

  // repeat count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg <= '0;
    end else if (stb.loadCnt) begin
      cntReg <= fifoData;
    end else if (stb.decCnt) begin
      cntReg <= cntReg - CNT_ONE;
    end
  end

  // first holding stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      h1Valid <= 1'b0;
      h1Tag   <= 1'b0;
      h1Data  <= '0;
    end else if (stb.loadH1) begin
      h1Valid <= 1'b1;
      h1Tag   <= stb.h1TagIn;
      h1Data  <= fifoData;
    end else if (stb.moveH1 && !stb.keepH1) begin
      h1Valid <= 1'b0;
      h1Tag   <= 1'b0;
    end
  end

  // output holding stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      h2Valid <= 1'b0;
      h2Tag   <= 1'b0;
      h2Data  <= '0;
    end else if (stb.moveH1) begin
      h2Valid <= 1'b1;
      h2Tag   <= h1Tag;
      h2Data  <= h1Data;
    end else if (stb.popH2) begin
      h2Valid <= 1'b0;
      h2Tag   <= 1'b0;
    end
  end

  always_comb begin
    sts.h1Valid = h1Valid;
    sts.h1Tag   = h1Tag;
    sts.h2Valid = h2Valid;
    sts.h2Tag   = h2Tag;
    sts.cntZero = (cntReg == '0);
    sts.cntOne  = (cntReg == CNT_ONE);
  end

  assign outData = h2Data;

endmodule

// File: rtl/rle_rx_ctrl.sv
module rle_rx_ctrl
  import rle_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        expandEn,
  input  logic        fifoValid,
  input  logic        fifoCmd,
  input  logic        hostPop,
  input  logic        hostTagRead,
  input  rle_status_t sts,
  output logic        fifoRd,
  output logic        replayActive,
  output rle_strobe_t stb
);

  rle_state_e state, stateNext;

  logic h2Leaves;
  logic moveH1;
  logic tagPending;
  logic h1Room;
  logic isCode;

  always_comb begin
    h2Leaves   = sts.h2Valid &&
                 ((hostPop && !sts.h2Tag) || (hostTagRead && sts.h2Tag));
    moveH1     = sts.h1Valid && (!sts.h2Valid || h2Leaves);
    replayActive = (state == ST_REPLAY);
    tagPending = (sts.h1Valid && sts.h1Tag) || (sts.h2Valid && sts.h2Tag);
    h1Room     = !sts.h1Valid || (moveH1 && !replayActive);
    fifoRd     = fifoValid && h1Room && !tagPending && !replayActive;
    isCode     = fifoCmd && expandEn;

    stb.moveH1  = moveH1;
    stb.keepH1  = replayActive && moveH1;
    stb.decCnt  = replayActive && moveH1;
    stb.popH2   = h2Leaves;
    stb.loadCnt = fifoRd && isCode;
    stb.loadH1  = fifoRd && !isCode;
    stb.h1TagIn = fifoCmd;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (stb.loadCnt) stateNext = ST_ARMED;
      end
      ST_ARMED: begin
        if (stb.loadH1 && !fifoCmd) begin
          stateNext = sts.cntZero ? ST_IDLE : ST_REPLAY;
        end
      end
      ST_REPLAY: begin
        if (stb.decCnt && sts.cntOne) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/rle_rx_expander.sv
module rle_rx_expander
  import rle_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              expandEn,
  input  logic              fifoValid,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              fifoCmd,
  output logic              fifoRd,
  input  logic              hostPop,
  input  logic              hostTagRead,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outTag,
  output logic              irq
);

  rle_strobe_t stb;
  rle_status_t sts;
  logic        replayActive;

  rle_rx_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .expandEn     (expandEn),
    .fifoValid    (fifoValid),
    .fifoCmd      (fifoCmd),
    .hostPop      (hostPop),
    .hostTagRead  (hostTagRead),
    .sts          (sts),
    .fifoRd       (fifoRd),
    .replayActive (replayActive),
    .stb          (stb)
  );

  rle_rx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .fifoData (fifoData),
    .sts      (sts),
    .outData  (outData)
  );

  assign outValid = sts.h2Valid;
  assign outTag   = sts.h2Tag;
  assign irq      = sts.h2Valid && sts.h2Tag;

endmodule

// File: rtl/rle_rx_expander_chk.sv
module rle_rx_expander_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              fifoRd,
  input logic              fifoValid,
  input logic              hostPop,
  input logic              hostTagRead,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outTag,
  input logic              irq,
  input logic              replayActive
);

  // R5: no FIFO read during replay
  a_r5_no_read_in_replay: assert property (@(posedge clk) disable iff (!rstN)
    replayActive |-> !fifoRd);

  // R8: no FIFO read while a tag waits at the output
  a_r8_no_read_tagged: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTag) |-> !fifoRd);

  // R7: tagged entry stays until its direct read
  a_r7_tag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTag && !hostTagRead) |=> (outValid && outTag && irq && $stable(outData)));

  // R7: direct read clears the interrupt
  a_r7_tag_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTag && hostTagRead) |=> !irq);

  // R9: untagged entry unaffected without a pop
  a_r9_untagged_holds: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outTag && !hostPop) |=> (outValid && !outTag && $stable(outData)));

  // R1: FIFO read only with an entry present
  a_r1_read_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> fifoValid);

endmodule

bind rle_rx_expander rle_rx_expander_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .fifoRd       (fifoRd),
  .fifoValid    (fifoValid),
  .hostPop      (hostPop),
  .hostTagRead  (hostTagRead),
  .outValid     (outValid),
  .outData      (outData),
  .outTag       (outTag),
  .irq          (irq),
  .replayActive (replayActive)
);

// File: tb/rle_rx_expander_test.sv
`timescale 1ns/1ps
module rle_rx_expander_test;
  localparam int DATA_W = 4;
  localparam int ENT_W  = DATA_W + 1;
  localparam int LIMIT  = 150000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, expandEn, fifoValid, fifoCmd, fifoRd;
  logic hostPop, hostTagRead, outValid, outTag, irq;
  logic [DATA_W-1:0] fifoData, outData;

  rle_rx_expander #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .expandEn(expandEn), .fifoValid(fifoValid),
    .fifoData(fifoData), .fifoCmd(fifoCmd), .fifoRd(fifoRd),
    .hostPop(hostPop), .hostTagRead(hostTagRead), .outValid(outValid),
    .outData(outData), .outTag(outTag), .irq(irq)
  );

  int compared = 0, mismatched = 0, cycles = 0, tagWait = 0;
  bit dogFired = 0, armed = 0, holdPend = 0, irqClrPend = 0;
  logic [DATA_W-1:0] pendCnt;
  logic [ENT_W-1:0] inQ[$];
  logic [ENT_W-1:0] expQ[$];
  logic [ENT_W-1:0] holdVal;
  string holdLbl, phase;

  task automatic check(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(bit cmd, int val);
    inQ.push_back({cmd, DATA_W'(val)});
  endtask

  // expected output derived from the requirements
  task automatic model(logic [ENT_W-1:0] ent);
    bit cmd = ent[DATA_W];
    logic [DATA_W-1:0] d = ent[DATA_W-1:0];
    if (cmd && expandEn) begin
      pendCnt = d; armed = 1;
    end else if (cmd) begin
      expQ.push_back({1'b1, d});
    end else if (armed) begin
      for (int k = 0; k <= int'(pendCnt); k++) expQ.push_back({1'b0, d});
      armed = 0;
    end else begin
      expQ.push_back({1'b0, d});
    end
  endtask

  task automatic step();
    logic [ENT_W-1:0] e;
    @(negedge clk);
    cycles++;
    if (holdPend) begin
      check(outValid && ({outTag, outData} == holdVal), holdLbl, "entry held",
            int'({outValid, outTag, outData}), int'({1'b1, holdVal}));
      holdPend = 0;
    end
    if (irqClrPend) begin
      check(!irq, "R7", "irq after tag read", int'(irq), 0);
      irqClrPend = 0;
    end
    if (outValid && outTag) begin
      check(irq, "R6", "irq while tagged", int'(irq), 1);
      tagWait++;
    end else tagWait = 0;
    hostPop = ($urandom_range(0, 3) != 0);
    if (outValid && outTag) hostTagRead = (tagWait >= 3);
    else hostTagRead = ($urandom_range(0, 7) == 0);
    fifoValid = (inQ.size() > 0) && ($urandom_range(0, 4) != 0);
    if (inQ.size() > 0) {fifoCmd, fifoData} = inQ[0];
    else {fifoCmd, fifoData} = '0;
    #1;
    if (outValid && ((hostPop && !outTag) || (hostTagRead && outTag))) begin
      if (expQ.size() == 0) begin
        check(0, phase, "unexpected output", int'({outTag, outData}), 0);
      end else begin
        e = expQ.pop_front();
        check({outTag, outData} == e, phase, "output entry",
              int'({outTag, outData}), int'(e));
      end
      if (outTag) irqClrPend = 1;
    end else if (outValid && (hostPop || hostTagRead)) begin
      holdPend = 1;
      holdVal  = {outTag, outData};
      holdLbl  = outTag ? "R7" : "R9";
    end
    if (fifoRd) begin
      check(fifoValid && (expQ.size() <= 1), "R5 R8", "occupancy at FIFO read",
            expQ.size(), 1);
      model(inQ.pop_front());
    end
  endtask

  task automatic drain();
    while ((inQ.size() > 0 || expQ.size() > 0) && !dogFired) begin
      step();
      if (cycles > LIMIT) dogFired = 1;
    end
    repeat (4) if (!dogFired) step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; expandEn = 1; fifoValid = 0; fifoCmd = 0; fifoData = '0;
    hostPop = 0; hostTagRead = 0;
    repeat (3) @(negedge clk);
    check(!outValid && !outTag && !irq, "R1", "reset outputs",
          int'({outValid, outTag, irq}), 0);
    rstN = 1;
    @(negedge clk); #1;
    check(!outValid && !irq && !fifoRd, "R1", "idle after reset",
          int'({outValid, irq, fifoRd}), 0);

    // directed, expansion on
    phase = "R2 R3 R4 R10";
    expandEn = 1;
    push(0, 10); push(0, 11);
    push(1, 0);  push(0, 5);
    push(1, 2);  push(0, 7);
    push(1, 15); push(0, 9);
    push(1, 3);  push(1, 1); push(0, 6);
    push(0, 12);
    drain();

    // directed, expansion off
    phase = "R6 R7 R9";
    expandEn = 0;
    push(1, 4); push(0, 1); push(0, 2); push(1, 0); push(1, 15); push(0, 3);
    drain();

    // random, expansion on
    phase = "R2 R3";
    expandEn = 1;
    for (int i = 0; i < 300; i++) push($urandom_range(0, 3) == 0, $urandom_range(0, 15));
    drain();

    // random, expansion off
    phase = "R6 R2";
    expandEn = 0;
    for (int i = 0; i < 150; i++) push($urandom_range(0, 3) == 0, $urandom_range(0, 15));
    drain();

    // random, expansion on again
    phase = "R3 R10";
    expandEn = 1;
    for (int i = 0; i < 200; i++) push($urandom_range(0, 2) == 0, $urandom_range(0, 15));
    drain();

    if (dogFired) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, LIMIT);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule